// File: doc/BRIEF.md
# Programmable Down-Counter Timer with Pulse-Width Capture

This block is a 16-bit timer. A small register port programs and reads it. Its count enable comes from one of sixteen selectable sources. Thirteen of these are raw asynchronous inputs, such as pulse outputs, quadrature lines and slow crystal-derived ticks. They are synchronised, optionally inverted and reduced to single-cycle edge events. One code selects the bus clock itself, divided by 1, 2 or 4. The two lowest codes never produce an event.

In counter mode the running count falls by one on each event. When it steps from one to zero, a sticky status flag is raised, and this flag can drive an interrupt. At zero the next event either reloads the programmed fixed count or leaves the counter parked at zero. In capture mode the block measures how long the selected input stays at its active level, in prescaled clock cycles. It places each completed measurement in the readable count and raises a ready flag.

Top module: `tmr_timer`

## Requirements
- R1: After reset the control word, the fixed count and the running count read 0, and `irq_o` is low.
- R2: The register map is: address 0 is control, 1 is the flag-clear alias, 2 is the fixed count, 3 is the running count. The control bits are: [3:0] source, [5:4] prescale, [6] polarity, [7] reload, [8] update, [9] interrupt enable, [10] capture mode, [11] capture ready (read-only), [15] zero flag. Bits 14:12 read 0. Writes to address 3 change nothing.
- R3: Source code 0xF advances once per prescaled bus cycle. Prescale 0 gives 1 cycle, 1 gives 2, and 2 or 3 give 4.
- R4: The zero flag sets when an event takes the count from 1 to 0. `irq_o` is high while the flag is set, the interrupt enable is set and capture mode is off.
- R5: A control write with bit 15 at 0 clears the zero flag. A control write with bit 15 at 1 leaves it alone. A write to address 1 clears the flag only when bit 15 is 1.
- R6: With reload set, an event at count 0 loads the fixed count. With reload clear, the count stays at 0.
- R7: With reload set and a fixed count of 0, the count stays at 0 without raising the flag. A non-zero fixed count written later is loaded at the next event, with no other action needed.
- R8: A fixed-count write with update set also loads the running count on the same edge. With update clear, the running count is untouched.
- R9: Codes 2 to 14 select `src_i[code-2]`. Only the selected input counts. Codes 0 and 1 never count.
- R10: With polarity 0, rising input edges are events. With polarity 1, falling edges are events.
- R11: In capture mode the count receives the number of prescaled cycles the input spent at its active level. It is loaded when the active level ends, and the ready bit is set at the same time.
- R12: The ready bit is 0 whenever capture mode is off. Any control write clears it, and it sets again only at the next completed measurement.
- R13: An edge on an external input changes the count on the third rising clock edge after the input changes, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data for rd_addr (combinational) |
| src_i | input | 13 | Raw asynchronous event sources for codes 2 to 14 |
| irq_o | output | 1 | Zero interrupt |

## Verification
The hardest state to reach from the ports is a captured width sitting beside a cleared ready bit. This requires a finished measurement, then a control write that rewrites the same mode, and then a second measurement of a different length. The stimulus holds a source input high for a fixed number of cycles, reads back the width and the ready bit, rewrites the control word unchanged, and then sends a shorter pulse. The polarity change is sequenced through a never-tick code, so that flipping the inversion does not itself create an edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_CLR   = 2'd1,
        ADDR_FIXED = 2'd2,
        ADDR_COUNT = 2'd3
    } reg_addr_e;

    // writable control fields, bit 10 down to bit 0
    typedef struct packed {
        logic       capture;
        logic       irq_en;
        logic       update;
        logic       reload;
        logic       invert;
        logic [1:0] prescale;
        logic [3:0] src_sel;
    } ctrl_t;

    localparam int CTRL_W    = $bits(ctrl_t);
    localparam int FLAG_BIT  = 15;
    localparam int SEL_W     = 4;
    localparam int FIRST_EXT = 2;

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int N_SRC = 13,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [1:0]       prescale_i,
    input  logic             invert_i,
    output logic             tick_o,
    output logic             level_o,
    output logic             fall_o,
    output logic             pstb_o
);
    import tmr_pkg::*;

    localparam logic [SEL_W-1:0] ALWAYS_CODE = '1;

    typedef struct packed {
        logic [N_SRC-1:0] s1;
        logic [N_SRC-1:0] s2;
        logic             prev;
        logic [1:0]       pcnt;
    } tg_state_t;

    tg_state_t st_d, st_q;
    logic       raw, lvl, is_ext, is_always;
    logic [1:0] mask;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = src_i;
        st_d.s2   = st_q.s1;
        st_d.pcnt = st_q.pcnt + 2'd1;

        is_always = (sel_i == ALWAYS_CODE);
        is_ext    = 1'b0;
        raw       = 1'b0;
        for (int k = 0; k < N_SRC; k++) begin
            if (sel_i == SEL_W'(k + FIRST_EXT)) begin
                raw    = st_q.s2[k];
                is_ext = 1'b1;
            end
        end

        lvl       = raw ^ invert_i;
        st_d.prev = lvl;

        case (prescale_i)
            2'd0:    mask = 2'b00;
            2'd1:    mask = 2'b01;
            default: mask = 2'b11;
        endcase
        pstb_o = ((st_q.pcnt & mask) == mask);

        tick_o  = is_always ? pstb_o : (is_ext & lvl & ~st_q.prev);
        fall_o  = is_ext & ~lvl & st_q.prev;
        level_o = is_always | (is_ext & lvl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             level_i,
    input  logic             fall_i,
    input  logic             pstb_i,
    input  logic             reload_i,
    input  logic             update_i,
    input  logic             capture_i,
    input  logic             fix_wr_i,
    input  logic [CNT_W-1:0] fix_data_i,
    input  logic             ctrl_wr_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] fixed_o,
    output logic             flag_o,
    output logic             ready_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] fixed;
        logic [CNT_W-1:0] meas;
        logic             flag;
        logic             ready;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        direct_load;

    always_comb begin
        st_d        = st_q;
        direct_load = fix_wr_i & update_i & ~capture_i;

        if (fix_wr_i) st_d.fixed = fix_data_i;

        if (capture_i) begin
            if (level_i && pstb_i && st_q.meas != CNT_MAX) st_d.meas = st_q.meas + CNT_ONE;
            if (fall_i) begin
                st_d.count = st_q.meas;
                st_d.meas  = '0;
                st_d.ready = 1'b1;
            end
            if (ctrl_wr_i) st_d.ready = 1'b0;
        end else begin
            st_d.meas  = '0;
            st_d.ready = 1'b0;
            if (direct_load) begin
                st_d.count = fix_data_i;
            end else if (tick_i) begin
                if (st_q.count == '0) begin
                    if (reload_i) st_d.count = st_q.fixed;
                end else begin
                    st_d.count = st_q.count - CNT_ONE;
                end
            end
        end

        if (flag_clr_i) st_d.flag = 1'b0;
        if (!capture_i && !direct_load && tick_i && st_q.count == CNT_ONE) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign fixed_o = st_q.fixed;
    assign flag_o  = st_q.flag;
    assign ready_o = st_q.ready;

    // R4
    flag_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_i && tick_i && st_q.count == CNT_ONE && !(fix_wr_i && update_i)) |=> st_q.flag);

    // R6
    park_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_i && !capture_i && st_q.count == '0 && !(fix_wr_i && update_i)) |=> (st_q.count == '0));

    // R8
    direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_i && fix_wr_i && update_i) |=> (st_q.count == $past(fix_data_i)));

    // R12
    ready_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_i || ctrl_wr_i) |=> !st_q.ready);

endmodule

// File: rtl/tmr_timer.sv
module tmr_timer #(
    parameter int CNT_W = 16,
    parameter int N_SRC = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic [N_SRC-1:0] src_i,
    output logic             irq_o
);
    import tmr_pkg::*;

    ctrl_t            ctrl_d, ctrl_q;
    logic             ctrl_wr, clr_wr, fix_wr, flag_clr;
    logic             tick_w, level_w, fall_w, pstb_w;
    logic [CNT_W-1:0] count_w, fixed_w;
    logic             flag_w, ready_w;

    always_comb begin
        ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
        clr_wr   = wr_en && (wr_addr == ADDR_CLR);
        fix_wr   = wr_en && (wr_addr == ADDR_FIXED);
        flag_clr = (ctrl_wr && !wr_data[FLAG_BIT]) || (clr_wr && wr_data[FLAG_BIT]);
        ctrl_d   = ctrl_q;
        if (ctrl_wr) ctrl_d = ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    tmr_tick_gen #(.N_SRC(N_SRC), .SEL_W(SEL_W)) tick_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .sel_i      (ctrl_q.src_sel),
        .prescale_i (ctrl_q.prescale),
        .invert_i   (ctrl_q.invert),
        .tick_o     (tick_w),
        .level_o    (level_w),
        .fall_o     (fall_w),
        .pstb_o     (pstb_w)
    );

    tmr_core #(.CNT_W(CNT_W)) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_w),
        .level_i    (level_w),
        .fall_i     (fall_w),
        .pstb_i     (pstb_w),
        .reload_i   (ctrl_q.reload),
        .update_i   (ctrl_q.update),
        .capture_i  (ctrl_q.capture),
        .fix_wr_i   (fix_wr),
        .fix_data_i (wr_data),
        .ctrl_wr_i  (ctrl_wr),
        .flag_clr_i (flag_clr),
        .count_o    (count_w),
        .fixed_o    (fixed_w),
        .flag_o     (flag_w),
        .ready_o    (ready_w)
    );

    always_comb begin
        case (rd_addr)
            ADDR_CTRL, ADDR_CLR: rd_data = CNT_W'({flag_w, 3'b000, ready_w, ctrl_q});
            ADDR_FIXED:          rd_data = fixed_w;
            default:             rd_data = count_w;
        endcase
    end

    assign irq_o = flag_w & ctrl_q.irq_en & ~ctrl_q.capture;

    // R2
    count_addr_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_COUNT) |=> (fixed_w == $past(fixed_w)));

endmodule

// File: tb/tmr_timer_tb_top.sv
`timescale 1ns/1ps
module tmr_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [12:0] src_i = '0;
    logic        irq_o;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    tmr_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .src_i(src_i), .irq_o(irq_o)
    );

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_near(input string req, input logic [15:0] act, input int exp);
        checks++;
        if (int'(act) < exp - 1 || int'(act) > exp + 1) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (+/-1)", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // control word: flag bit 15 kept at 1 so the write leaves the flag alone
    function automatic logic [15:0] cw(input logic [3:0] sel, input logic [1:0] div, input logic inv,
                                       input logic rel, input logic upd, input logic ien, input logic cap);
        return {1'b1, 4'b0000, cap, ien, upd, rel, inv, div, sel};
    endfunction

    task automatic pulse(input int idx, input int hi, input int lo);
        @(negedge clk);
        src_i[idx] = 1'b1;
        repeat (hi) @(negedge clk);
        src_i[idx] = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(2'd0, v); check("R1 ctrl", v, 16'h0000);
        rd(2'd2, v); check("R1 fixed", v, 16'h0000);
        rd(2'd3, v); check("R1 count", v, 16'h0000);
        check("R1 irq", {15'd0, irq_o}, 16'h0000);
    endtask

    task automatic t_regs;
        logic [15:0] v;
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v); check("R2 reserved read zero", v, 16'h07FF);
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'h1234);
        rd(2'd2, v); check("R2 fixed readback", v, 16'h1234);
        rd(2'd3, v); check("R8 no update keeps count", v, 16'h0000);
        wr(2'd3, 16'hBEEF);
        rd(2'd3, v); check("R2 count write ignored", v, 16'h0000);
        rd(2'd2, v); check("R2 count write leaves fixed", v, 16'h1234);
    endtask

    task automatic t_update;
        logic [15:0] v;
        wr(2'd0, cw(4'h0, 2'd0, 0, 0, 1, 0, 0));
        wr(2'd2, 16'h00AB);
        rd(2'd3, v); check("R8 update loads count", v, 16'h00AB);
    endtask

    task automatic t_prescale;
        logic [15:0] v;
        int          divs[4] = '{1, 2, 4, 4};
        for (int p = 0; p < 4; p++) begin
            wr(2'd0, cw(4'h0, 2'(p), 0, 0, 1, 0, 0));
            wr(2'd2, 16'd100);
            wr(2'd0, cw(4'hF, 2'(p), 0, 0, 1, 0, 0));
            waitn(40);
            rd(2'd3, v);
            check_near($sformatf("R3 prescale code %0d", p), v, 100 - 40 / divs[p]);
        end
    endtask

    task automatic t_flag;
        logic [15:0] v;
        wr(2'd0, cw(4'h0, 2'd0, 0, 0, 1, 1, 0) & 16'h7FFF);
        wr(2'd2, 16'd3);
        check("R4 irq low before zero", {15'd0, irq_o}, 16'h0000);
        wr(2'd0, cw(4'hF, 2'd0, 0, 0, 1, 1, 0));
        waitn(10);
        rd(2'd3, v); check("R6 parks at zero", v, 16'h0000);
        rd(2'd0, v); check("R4 flag set", {15'd0, v[15]}, 16'h0001);
        check("R4 irq high", {15'd0, irq_o}, 16'h0001);
        wr(2'd0, cw(4'hF, 2'd0, 0, 0, 1, 0, 0));
        check("R4 irq gated by enable", {15'd0, irq_o}, 16'h0000);
        rd(2'd0, v); check("R5 write of one keeps flag", {15'd0, v[15]}, 16'h0001);
        wr(2'd0, cw(4'hF, 2'd0, 0, 0, 1, 1, 0) & 16'h7FFF);
        rd(2'd0, v); check("R5 ctrl zero clears flag", {15'd0, v[15]}, 16'h0000);
        check("R5 irq drops", {15'd0, irq_o}, 16'h0000);
        wr(2'd2, 16'd2);
        waitn(6);
        wr(2'd1, 16'h0000);
        rd(2'd0, v); check("R5 alias zero keeps flag", {15'd0, v[15]}, 16'h0001);
        wr(2'd1, 16'h8000);
        rd(2'd0, v); check("R5 alias one clears flag", {15'd0, v[15]}, 16'h0000);
    endtask

    task automatic t_reload;
        logic [15:0] v;
        wr(2'd0, cw(4'h0, 2'd0, 0, 1, 1, 0, 0));
        wr(2'd2, 16'd5);
        wr(2'd0, cw(4'hF, 2'd0, 0, 1, 1, 0, 0));
        waitn(7);
        rd(2'd3, v); check("R6 reload from fixed", v, 16'd4);
    endtask

    task automatic t_zero_fixed;
        logic [15:0] v;
        wr(2'd0, cw(4'h0, 2'd0, 0, 1, 1, 0, 0) & 16'h7FFF);
        wr(2'd2, 16'd0);
        wr(2'd0, cw(4'hF, 2'd0, 0, 1, 0, 0, 0));
        waitn(5);
        rd(2'd3, v); check("R7 zero fixed holds zero", v, 16'd0);
        rd(2'd0, v); check("R7 no flag on zero reload", {15'd0, v[15]}, 16'h0000);
        wr(2'd2, 16'd3);
        waitn(2);
        rd(2'd3, v); check("R7 nonzero fixed starts", v, 16'd2);
    endtask

    task automatic t_ext;
        logic [15:0] v;
        wr(2'd0, cw(4'h0, 2'd0, 0, 0, 1, 0, 0));
        wr(2'd2, 16'd50);
        wr(2'd0, cw(4'h2, 2'd0, 0, 0, 1, 0, 0));
        for (int i = 0; i < 3; i++) pulse(0, 3, 3);
        waitn(4);
        rd(2'd3, v); check("R9 code 2 counts src 0", v, 16'd47);
        wr(2'd0, cw(4'hE, 2'd0, 0, 0, 1, 0, 0));
        for (int i = 0; i < 4; i++) pulse(12, 3, 3);
        for (int i = 0; i < 2; i++) pulse(0, 3, 3);
        waitn(4);
        rd(2'd3, v); check("R9 code 14 counts only src 12", v, 16'd43);
        wr(2'd0, cw(4'h1, 2'd0, 0, 0, 1, 0, 0));
        pulse(0, 3, 3); pulse(12, 3, 3);
        wr(2'd0, cw(4'h0, 2'd1, 1, 0, 1, 0, 0));
        pulse(1, 3, 3);
        waitn(4);
        rd(2'd3, v); check("R9 codes 0 and 1 never count", v, 16'd43);
        wr(2'd0, cw(4'h0, 2'd0, 0, 0, 1, 0, 0));
    endtask

    task automatic t_latency;
        logic [15:0] v;
        wr(2'd0, cw(4'h2, 2'd0, 0, 0, 1, 0, 0));
        @(negedge clk);
        src_i[0] = 1'b1;
        waitn(2);
        rd(2'd3, v); check("R13 not yet after two edges", v, 16'd43);
        waitn(1);
        rd(2'd3, v); check("R13 counted on third edge", v, 16'd42);
        src_i[0] = 1'b0;
        waitn(4);
    endtask

    task automatic t_polarity;
        logic [15:0] v;
        wr(2'd0, cw(4'h0, 2'd0, 1, 0, 1, 0, 0));
        wr(2'd0, cw(4'h2, 2'd0, 1, 0, 1, 0, 0));
        @(negedge clk);
        src_i[0] = 1'b1;
        waitn(5);
        rd(2'd3, v); check("R10 rise ignored when inverted", v, 16'd42);
        src_i[0] = 1'b0;
        waitn(5);
        rd(2'd3, v); check("R10 fall counted when inverted", v, 16'd41);
        wr(2'd0, cw(4'h0, 2'd0, 0, 0, 1, 0, 0));
    endtask

    task automatic t_capture;
        logic [15:0] v;
        wr(2'd0, cw(4'h2, 2'd0, 0, 0, 0, 0, 1));
        pulse(0, 10, 5);
        rd(2'd3, v); check("R11 captured width", v, 16'd10);
        rd(2'd0, v); check("R11 ready set", {15'd0, v[11]}, 16'h0001);
        wr(2'd0, cw(4'h2, 2'd0, 0, 0, 0, 0, 1));
        rd(2'd0, v); check("R12 ctrl write clears ready", {15'd0, v[11]}, 16'h0000);
        rd(2'd3, v); check("R12 width kept after clear", v, 16'd10);
        pulse(0, 7, 5);
        rd(2'd3, v); check("R11 second width", v, 16'd7);
        rd(2'd0, v); check("R12 ready sets again", {15'd0, v[11]}, 16'h0001);
        wr(2'd0, cw(4'h2, 2'd0, 0, 0, 0, 0, 0));
        pulse(0, 4, 5);
        rd(2'd0, v); check("R12 ready clear out of capture", {15'd0, v[11]}, 16'h0000);
    endtask

    initial begin
        waitn(3);
        rst_n = 1'b1;
        waitn(2);
        t_reset;
        t_regs;
        t_update;
        t_prescale;
        t_flag;
        t_reload;
        t_zero_fixed;
        t_ext;
        t_latency;
        t_polarity;
        t_capture;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule